// File: doc/BRIEF.md
# Power Stage Fault Protection Controller

This block makes one shutdown decision for a four half-bridge power stage. It watches four fault sources. The first is a set of overcurrent flags, one for the high-side FET and one for the low-side FET of each bridge. The second is a junction temperature code. The third and fourth are an undervoltage and an overvoltage check on one supply voltage code. When any source is active, all four bridges go to high impedance together. No bridge is ever shut down on its own.

The temperature and supply checks compare their codes against parameter thresholds. Each check has a separate trip level and release level, which gives it hysteresis. These three checks drive the outputs combinationally, so high impedance appears in the same cycle the code crosses the trip level. The overcurrent flags come from another clock domain, so they pass through a two-flop synchronizer first. Overcurrent shutdown then latches.

No source releases on its first clear sample. Each one needs its clear condition to hold for a programmable number of consecutive cycles before it lets go. An active-low fault pin reflects only the overcurrent shutdown. A sticky copy of that pin is kept for a status register. A read-clear strobe clears the sticky copy, but only when no overcurrent shutdown is active.

Top module: `pstage_guard`

## Requirements
- R1: Each of the eight overcurrent flags (bit 2b is the high-side FET of bridge b, bit 2b+1 the low-side FET) forces all four `hiz_o` bits to 1. The four bits are always equal.
- R2: A flag driven high before rising edge k raises `hiz_o` after edge k+1, and not after edge k (two synchronizer stages).
- R3: `fault_no` is 0 while an overcurrent shutdown is in force and 1 otherwise. It stays 1 during a shutdown caused only by temperature or supply.
- R4: `fault_sticky_o` becomes 1 one cycle after `fault_no` goes low. It stays 1 after `fault_no` returns high.
- R5: A cycle with `stat_rd_clr_i` high clears `fault_sticky_o` only if no overcurrent shutdown is active in that cycle. Otherwise the strobe has no effect.
- R6: A `temp_code_i` above `OT_TRIP` sets `hiz_o` in the same cycle. A code equal to `OT_TRIP` does not trip. Once tripped, a code above `OT_REL` holds the shutdown indefinitely.
- R7: A thermal, undervoltage or overvoltage shutdown releases after `REL_CYC` consecutive rising edges that sample the clear condition. Any sample that is not clear restarts the count.
- R8: A `vsup_code_i` below `UV_TRIP` sets `hiz_o` in the same cycle. The shutdown releases only through R7, with a code above `UV_REL`. Codes from `UV_TRIP` up to `UV_REL` hold it.
- R9: A `vsup_code_i` above `OV_TRIP` sets `hiz_o` in the same cycle. The shutdown releases only through R7, with a code below `OV_REL`. Codes from `OV_REL` up to `OV_TRIP` hold it.
- R10: Overcurrent release follows R7 on the synchronized flags. `hiz_o` drops `REL_CYC`+2 edges after the last flag is driven low.
- R11: During and after reset, with nominal codes, `hiz_o` is 0, `fault_no` is 1 and `fault_sticky_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oc_flags_i | input | 2*N_BRIDGE | Per-FET overcurrent flags, asynchronous |
| temp_code_i | input | TEMP_W | Junction temperature code |
| vsup_code_i | input | VOLT_W | Supply voltage code |
| stat_rd_clr_i | input | 1 | Read-clear strobe for the sticky bit |
| hiz_o | output | N_BRIDGE | High-impedance enable per half-bridge |
| fault_no | output | 1 | Live overcurrent fault, active low |
| fault_sticky_o | output | 1 | Sticky overcurrent fault status |

## Verification
The bench raises each of the eight flags alone. This exposes a design that shuts down only the offending bridge, or that drops a low-side flag. It samples one edge early and at the exact release edge, which catches a missing synchronizer stage or a counter that is off by one.

Trip codes are held exactly on each threshold and inside each hysteresis band. This catches a comparison of the wrong strictness, or a release at the trip level instead of the release level. A clear sample is interrupted by one band sample, which catches a counter that does not restart.

The read-clear strobe is pulsed while the latched shutdown is still counting toward release. A design that clears the sticky bit there would lose the status.

// File: rtl/pstage_guard_pkg.sv
package pstage_guard_pkg;
  localparam int unsigned N_SRC = 4;
  typedef enum logic [1:0] {
    SRC_OC = 2'd0,
    SRC_OT = 2'd1,
    SRC_UV = 2'd2,
    SRC_OV = 2'd3
  } fault_src_e;
endpackage

// File: rtl/pstage_oc_sync.sv
module pstage_oc_sync #(
  parameter int unsigned N_BRIDGE = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [2*N_BRIDGE-1:0]   flags_i,
  output logic                    any_o
);
  localparam int unsigned N_FLAGS = 2 * N_BRIDGE;

  logic [N_FLAGS-1:0]  s1_q, s2_q;
  logic [N_BRIDGE-1:0] bridge_oc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= flags_i;
      s2_q <= s1_q;
    end
  end

  for (genvar b = 0; b < N_BRIDGE; b++) begin : g_bridge
    assign bridge_oc[b] = s2_q[2*b] | s2_q[2*b+1];
  end

  assign any_o = |bridge_oc;

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i == '0) |=> ##1 (s2_q == '0)) else $error("sync stage skipped"); // R2
endmodule

// File: rtl/pstage_hold_release.sv
module pstage_hold_release #(
  parameter int unsigned REL_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic engage_i,
  input  logic clear_i,
  output logic active_o
);
  localparam int unsigned CNT_W = (REL_CYC > 1) ? $clog2(REL_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REL_CYC - 1);

  logic             state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else if (engage_i) begin
      state_q <= 1'b1;
      cnt_q   <= '0;
    end else if (state_q && clear_i) begin
      if (cnt_q == LAST) begin
        state_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  // engage drives the output without a register stage
  assign active_o = state_q | engage_i;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST) else $error("release counter out of range"); // R7
  AST_BAND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q && !clear_i) |=> state_q) else $error("released without clear"); // R7
  AST_RELEASE_AFTER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(state_q) |-> $past(clear_i)) else $error("release not preceded by clear"); // R7
endmodule

// File: rtl/pstage_guard.sv
module pstage_guard
  import pstage_guard_pkg::*;
#(
  parameter int unsigned N_BRIDGE = 4,
  parameter int unsigned TEMP_W   = 8,
  parameter int unsigned VOLT_W   = 10,
  parameter int unsigned OT_TRIP  = 150,
  parameter int unsigned OT_REL   = 135,
  parameter int unsigned UV_TRIP  = 84,
  parameter int unsigned UV_REL   = 85,
  parameter int unsigned OV_TRIP  = 275,
  parameter int unsigned OV_REL   = 272,
  parameter int unsigned REL_CYC  = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2*N_BRIDGE-1:0] oc_flags_i,
  input  logic [TEMP_W-1:0]     temp_code_i,
  input  logic [VOLT_W-1:0]     vsup_code_i,
  input  logic                  stat_rd_clr_i,
  output logic [N_BRIDGE-1:0]   hiz_o,
  output logic                  fault_no,
  output logic                  fault_sticky_o
);
  localparam logic [TEMP_W-1:0] OT_TRIP_C = TEMP_W'(OT_TRIP);
  localparam logic [TEMP_W-1:0] OT_REL_C  = TEMP_W'(OT_REL);
  localparam logic [VOLT_W-1:0] UV_TRIP_C = VOLT_W'(UV_TRIP);
  localparam logic [VOLT_W-1:0] UV_REL_C  = VOLT_W'(UV_REL);
  localparam logic [VOLT_W-1:0] OV_TRIP_C = VOLT_W'(OV_TRIP);
  localparam logic [VOLT_W-1:0] OV_REL_C  = VOLT_W'(OV_REL);

  logic             oc_any;
  logic [N_SRC-1:0] engage, clear, active;
  logic             shut;
  logic             sticky_q;

  pstage_oc_sync #(.N_BRIDGE(N_BRIDGE)) u_oc_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flags_i(oc_flags_i),
    .any_o  (oc_any)
  );

  always_comb begin
    engage[SRC_OC] = oc_any;
    clear[SRC_OC]  = ~oc_any;
    engage[SRC_OT] = temp_code_i > OT_TRIP_C;
    clear[SRC_OT]  = temp_code_i <= OT_REL_C;
    engage[SRC_UV] = vsup_code_i < UV_TRIP_C;
    clear[SRC_UV]  = vsup_code_i > UV_REL_C;
    engage[SRC_OV] = vsup_code_i > OV_TRIP_C;
    clear[SRC_OV]  = vsup_code_i < OV_REL_C;
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    pstage_hold_release #(.REL_CYC(REL_CYC)) u_hold (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .engage_i(engage[s]),
      .clear_i (clear[s]),
      .active_o(active[s])
    );
  end

  assign shut = |active;

  for (genvar b = 0; b < N_BRIDGE; b++) begin : g_hiz
    assign hiz_o[b] = shut;
  end

  assign fault_no = ~active[SRC_OC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             sticky_q <= 1'b0;
    else if (active[SRC_OC])                 sticky_q <= 1'b1;
    else if (stat_rd_clr_i)                  sticky_q <= 1'b0;
  end

  assign fault_sticky_o = sticky_q;

  AST_BRIDGES_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(hiz_o) == 0) || ($countones(hiz_o) == N_BRIDGE)) else $error("bridges split"); // R1
  AST_PIN_TRACKS_OC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_any |-> !fault_no) else $error("fault pin high during overcurrent"); // R3
  AST_STICKY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_no |=> fault_sticky_o) else $error("sticky not set"); // R4
  AST_STICKY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_sticky_o) |-> ($past(stat_rd_clr_i) && $past(fault_no))) else $error("sticky lost"); // R5
  AST_OT_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_code_i > OT_TRIP_C) |-> &hiz_o) else $error("thermal trip late"); // R6
  AST_UV_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsup_code_i < UV_TRIP_C) |-> &hiz_o) else $error("undervoltage trip late"); // R8
  AST_OV_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsup_code_i > OV_TRIP_C) |-> &hiz_o) else $error("overvoltage trip late"); // R9
endmodule

// File: tb/pstage_guard_test.sv
`timescale 1ns/1ps
module pstage_guard_test;
  localparam int unsigned NB  = 4;
  localparam int unsigned REL = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2*NB-1:0] oc_flags_i = '0;
  logic [7:0]    temp_code_i = 8'd25;
  logic [9:0]    vsup_code_i = 10'd120;
  logic          stat_rd_clr_i = 1'b0;
  logic [NB-1:0] hiz_o;
  logic          fault_no;
  logic          fault_sticky_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pstage_guard #(.N_BRIDGE(NB), .REL_CYC(REL)) uut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .oc_flags_i    (oc_flags_i),
    .temp_code_i   (temp_code_i),
    .vsup_code_i   (vsup_code_i),
    .stat_rd_clr_i (stat_rd_clr_i),
    .hiz_o         (hiz_o),
    .fault_no      (fault_no),
    .fault_sticky_o(fault_sticky_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R11 hiz in reset", hiz_o, 0);
    chk("R11 pin in reset", fault_no, 1);
    chk("R11 sticky in reset", fault_sticky_o, 0);
    step(2);
    rst_ni = 1'b1;
    step(2);
    chk("R11 hiz after reset", hiz_o, 0);
    chk("R11 pin after reset", fault_no, 1);
  endtask

  task automatic t_oc_each_flag();
    for (int f = 0; f < 2*NB; f++) begin
      oc_flags_i = 8'(1 << f);
      step(1);
      chk("R2 one edge not enough", hiz_o, 0);
      step(1);
      chk("R1 all bridges off", hiz_o, 4'hF);
      chk("R3 pin low on overcurrent", fault_no, 0);
      oc_flags_i = '0;
      step(REL + 1);
      chk("R10 held before release", hiz_o, 4'hF);
      step(1);
      chk("R10 released", hiz_o, 0);
      chk("R3 pin high after release", fault_no, 1);
      chk("R4 sticky remains", fault_sticky_o, 1);
      stat_rd_clr_i = 1'b1;
      step(1);
      stat_rd_clr_i = 1'b0;
      chk("R5 clear when idle", fault_sticky_o, 0);
    end
  endtask

  task automatic t_sticky_clear_blocked();
    oc_flags_i = 8'h30;
    step(2);
    stat_rd_clr_i = 1'b1;
    step(1);
    stat_rd_clr_i = 1'b0;
    chk("R5 clear ignored while flag set", fault_sticky_o, 1);
    oc_flags_i = '0;
    step(4);
    chk("R3 pin low while counting", fault_no, 0);
    stat_rd_clr_i = 1'b1;
    step(1);
    stat_rd_clr_i = 1'b0;
    chk("R5 clear ignored while latched", fault_sticky_o, 1);
    step(REL);
    chk("R10 released", hiz_o, 0);
    chk("R4 sticky kept", fault_sticky_o, 1);
    stat_rd_clr_i = 1'b1;
    step(1);
    stat_rd_clr_i = 1'b0;
    chk("R5 clear after release", fault_sticky_o, 0);
  endtask

  task automatic t_thermal();
    temp_code_i = 8'd150;
    #1;
    chk("R6 at trip no shutdown", hiz_o, 0);
    temp_code_i = 8'd151;
    #1;
    chk("R6 same cycle trip", hiz_o, 4'hF);
    chk("R3 pin stays high on thermal", fault_no, 1);
    step(1);
    temp_code_i = 8'd136;
    step(REL + 3);
    chk("R6 band holds", hiz_o, 4'hF);
    temp_code_i = 8'd135;
    step(REL - 1);
    chk("R7 thermal not yet released", hiz_o, 4'hF);
    step(1);
    chk("R7 thermal released", hiz_o, 0);
    chk("R4 sticky untouched by thermal", fault_sticky_o, 0);
    temp_code_i = 8'd200;
    step(1);
    temp_code_i = 8'd100;
    step(REL - 2);
    temp_code_i = 8'd140;
    step(1);
    temp_code_i = 8'd100;
    step(REL - 1);
    chk("R7 count restarted", hiz_o, 4'hF);
    step(1);
    chk("R7 released after restart", hiz_o, 0);
    temp_code_i = 8'd25;
  endtask

  task automatic t_undervoltage();
    vsup_code_i = 10'd84;
    #1;
    chk("R8 at trip no shutdown", hiz_o, 0);
    vsup_code_i = 10'd83;
    #1;
    chk("R8 same cycle trip", hiz_o, 4'hF);
    step(1);
    vsup_code_i = 10'd85;
    step(REL + 2);
    chk("R8 band holds", hiz_o, 4'hF);
    vsup_code_i = 10'd86;
    step(REL - 1);
    chk("R8 not yet released", hiz_o, 4'hF);
    step(1);
    chk("R8 released", hiz_o, 0);
    vsup_code_i = 10'd120;
  endtask

  task automatic t_overvoltage();
    vsup_code_i = 10'd275;
    #1;
    chk("R9 at trip no shutdown", hiz_o, 0);
    vsup_code_i = 10'd276;
    #1;
    chk("R9 same cycle trip", hiz_o, 4'hF);
    step(1);
    vsup_code_i = 10'd272;
    step(REL + 2);
    chk("R9 band holds", hiz_o, 4'hF);
    vsup_code_i = 10'd271;
    step(REL - 1);
    chk("R9 not yet released", hiz_o, 4'hF);
    step(1);
    chk("R9 released", hiz_o, 0);
    vsup_code_i = 10'd120;
  endtask

  initial begin
    t_reset();
    t_oc_each_flag();
    t_sticky_clear_blocked();
    t_thermal();
    t_undervoltage();
    t_overvoltage();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule